// File: doc/BRIEF.md
# Programmable Interval Down-Counter Timer

This block is a 32-bit interval timer that software drives through a small word-addressed register bus. The counter counts down one step per clock from a programmed period. When it has reached zero it either reloads and carries on (continuous mode) or reloads and halts until software starts it again (one-shot mode). Each expiry raises a sticky timeout flag, which can also drive an interrupt line.

The period and the live count are wider than the half-word registers that hold them. The period is therefore written as two 16-bit halves. The count is read through a two-register snapshot: a write to the low snapshot register captures the whole live count in one clock, so the two later reads give one coherent value. Start and stop are write-only strobe bits in the control register, kept apart from the stored mode bits. With a period of all ones in continuous mode, the inverted snapshot serves as a free-running up-counting time base.

Top module: `itmr_top`

## Requirements
- R1: After reset, word 0 (status) and word 1 (control) read 0, words 2 and 3 (period low and high) each read 0x0000_FFFF, and words 4 and 5 (snapshot low and high) read 0. The counter is stopped and holds 0xFFFF_FFFF.
- R2: A write to word 2 stores data bits 15:0 as period bits 15:0, and a write to word 3 stores data bits 15:0 as period bits 31:16. Reads of words 2 to 5 return the stored half in bits 15:0 and zero in bits 31:16.
- R3: A write to either period word loads the counter with the complete updated 32-bit period on the same clock edge. The running state is unchanged.
- R4: A write to word 1 with bit 2 set starts the counter without changing its value. While the counter runs it decreases by one on every clock, and status bit 1 reads 1.
- R5: A write to word 1 with bit 3 set stops the counter, which then holds its value. When bits 2 and 3 are written together, the counter stops.
- R6: When a running counter is at zero, the next clock edge reloads it from the period and sets status bit 0 (timeout). A counter started at period P therefore reaches its first timeout P+1 clocks after the start edge.
- R7: When control bit 1 is 1 (continuous), the counter keeps running after each reload. From a start at period P, its value after n clocks is P − (n mod (P+1)).
- R8: When control bit 1 is 0 (one-shot), the expiry edge reloads the period and stops the counter. The counter then holds the period until the next start strobe.
- R9: Any write to word 0 clears the timeout flag, whatever the data. If an expiry occurs on the same edge, the flag stays set.
- R10: Any write to word 4, whatever the data, copies the count held before that edge into the snapshot. Word 4 then reads count bits 15:0 and word 5 reads count bits 31:16. A write to word 5 leaves the snapshot unchanged.
- R11: Output irq is 1 exactly when control bit 0 (interrupt enable) is 1 and the timeout flag is set.
- R12: Control bits 1:0 are stored and read back from word 1. The strobe bits 3:2 always read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from bus_addr |
| irq | output | 1 | Timeout interrupt request |

## Verification
The embedded assertions check the counter's cycle-level behaviour on every clock: a decrement by one while running, a hold while stopped, a reload from the period at zero, a one-shot halt on expiry, and stop taking priority over start. On every cycle they also check that the timeout flag is set on expiry and cleared on a status write, that the snapshot captures the live count, and that a write to the high snapshot word is ignored. Only the bench's scenarios can show the end-to-end results. These include the count seen through the split registers after a given number of clocks in continuous mode, including wrap-around and a borrow across the half boundary. They also include the reset values as read over the bus, the masking of the upper read bits, the interrupt gating, and the one-shot timer waiting for a new start.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   // Word slots of the register map
   localparam int unsigned WRD_STATUS = 0;
   localparam int unsigned WRD_CTRL   = 1;
   localparam int unsigned WRD_PER_LO = 2;
   localparam int unsigned WRD_PER_HI = 3;
   localparam int unsigned WRD_SNP_LO = 4;
   localparam int unsigned WRD_SNP_HI = 5;
   localparam int unsigned NUM_WORDS  = 6;

   // Status bits
   localparam int unsigned ST_TIMEOUT = 0;
   localparam int unsigned ST_RUNNING = 1;

   // Control bits
   localparam int unsigned CT_IRQ_EN  = 0;
   localparam int unsigned CT_CONT    = 1;
   localparam int unsigned CT_START   = 2;
   localparam int unsigned CT_STOP    = 3;

   typedef struct packed {
      logic cont;
      logic irq_en;
   } itmr_ctrl_t;
endpackage

// File: rtl/itmr_counter.sv
module itmr_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_stb,
   input  logic             stop_stb,
   input  logic             load_stb,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   input  logic             cont,
   output logic [CNT_W-1:0] count,
   output logic             running,
   output logic             expire
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic at_zero;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("itmr_counter: CNT_W must be at least 2");
      end
   endgenerate

   assign at_zero = (count == ZERO);
   assign expire  = running && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '1;
      end else if (load_stb) begin
         count <= load_val;
      end else if (running) begin
         count <= at_zero ? period : (count - ONE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
      end else if (stop_stb) begin
         running <= 1'b0;
      end else if (start_stb) begin
         running <= 1'b1;
      end else if (expire && !cont) begin
         running <= 1'b0;
      end
   end

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !at_zero && !load_stb) |=> (count == $past(count) - ONE)); // R4
   AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !load_stb) |=> $stable(count)); // R5
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      stop_stb |=> !running); // R5
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (running && at_zero && !load_stb) |=> (count == $past(period))); // R6
   AST_CONT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (running && at_zero && cont && !stop_stb) |=> running); // R7
   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (running && at_zero && !cont && !start_stb) |=> !running); // R8
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
   import itmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              running,
   input  logic              expire,
   output logic              start_stb,
   output logic              stop_stb,
   output logic              load_stb,
   output logic [CNT_W-1:0]  load_val,
   output logic [CNT_W-1:0]  period,
   output itmr_ctrl_t        ctrl,
   output logic              timeout
);
   localparam int unsigned HALF_W = CNT_W / 2;
   localparam int unsigned PAD_W  = BUS_W - HALF_W;
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(WRD_STATUS);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(WRD_CTRL);
   localparam logic [ADDR_W-1:0] A_PER_LO = ADDR_W'(WRD_PER_LO);
   localparam logic [ADDR_W-1:0] A_PER_HI = ADDR_W'(WRD_PER_HI);
   localparam logic [ADDR_W-1:0] A_SNP_LO = ADDR_W'(WRD_SNP_LO);
   localparam logic [ADDR_W-1:0] A_SNP_HI = ADDR_W'(WRD_SNP_HI);

   generate
      if ((CNT_W % 2) != 0) begin : g_bad_cnt
         $error("itmr_regs: CNT_W must be even");
      end
      if (BUS_W <= HALF_W || BUS_W < 4) begin : g_bad_bus
         $error("itmr_regs: BUS_W must exceed CNT_W/2 and hold the control bits");
      end
      if ((2 ** ADDR_W) < NUM_WORDS) begin : g_bad_addr
         $error("itmr_regs: ADDR_W too small for the register map");
      end
   endgenerate

   logic             wr;
   logic             wr_status, wr_ctrl, wr_snp_lo;
   logic [1:0]       per_hit;
   logic [CNT_W-1:0] period_q, snap_q;
   logic             timeout_q;
   itmr_ctrl_t       ctrl_q;
   logic             unused_wdata;

   assign wr        = bus_sel && bus_we;
   assign wr_status = wr && (bus_addr == A_STATUS);
   assign wr_ctrl   = wr && (bus_addr == A_CTRL);
   assign wr_snp_lo = wr && (bus_addr == A_SNP_LO);
   assign unused_wdata = ^bus_wdata[BUS_W-1:HALF_W];

   // One half-word slice of the period per register word
   generate
      for (genvar h = 0; h < 2; h++) begin : g_per_half
         localparam logic [ADDR_W-1:0] A_HALF = ADDR_W'(WRD_PER_LO + h);
         assign per_hit[h] = wr && (bus_addr == A_HALF);
         assign load_val[h*HALF_W +: HALF_W] = per_hit[h] ? bus_wdata[HALF_W-1:0]
                                                          : period_q[h*HALF_W +: HALF_W];
      end
   endgenerate

   assign load_stb  = |per_hit;
   assign start_stb = wr_ctrl && bus_wdata[CT_START];
   assign stop_stb  = wr_ctrl && bus_wdata[CT_STOP];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '1;
      end else if (load_stb) begin
         period_q <= load_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q.cont   <= bus_wdata[CT_CONT];
         ctrl_q.irq_en <= bus_wdata[CT_IRQ_EN];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timeout_q <= 1'b0;
      end else if (expire) begin
         timeout_q <= 1'b1;
      end else if (wr_status) begin
         timeout_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else if (wr_snp_lo) begin
         snap_q <= count;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_STATUS: begin
            bus_rdata[ST_TIMEOUT] = timeout_q;
            bus_rdata[ST_RUNNING] = running;
         end
         A_CTRL: begin
            bus_rdata[CT_IRQ_EN] = ctrl_q.irq_en;
            bus_rdata[CT_CONT]   = ctrl_q.cont;
         end
         A_PER_LO: bus_rdata = {{PAD_W{1'b0}}, period_q[HALF_W-1:0]};
         A_PER_HI: bus_rdata = {{PAD_W{1'b0}}, period_q[CNT_W-1:HALF_W]};
         A_SNP_LO: bus_rdata = {{PAD_W{1'b0}}, snap_q[HALF_W-1:0]};
         A_SNP_HI: bus_rdata = {{PAD_W{1'b0}}, snap_q[CNT_W-1:HALF_W]};
         default:  bus_rdata = '0;
      endcase
   end

   assign period  = period_q;
   assign ctrl    = ctrl_q;
   assign timeout = timeout_q;

   AST_TIMEOUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> timeout_q); // R6
   AST_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && !expire) |=> !timeout_q); // R9
   AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb |=> $stable(period_q)); // R2
   AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_snp_lo |=> (snap_q == $past(count))); // R10
   AST_SNAP_HI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == A_SNP_HI) |=> $stable(snap_q)); // R10
endmodule

// File: rtl/itmr_top.sv
module itmr_top
   import itmr_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   logic             start_stb, stop_stb, load_stb;
   logic [CNT_W-1:0] load_val, period, count;
   logic             running, expire, timeout;
   itmr_ctrl_t       ctrl;

   itmr_regs #(
      .CNT_W  (CNT_W),
      .BUS_W  (BUS_W),
      .ADDR_W (ADDR_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .count     (count),
      .running   (running),
      .expire    (expire),
      .start_stb (start_stb),
      .stop_stb  (stop_stb),
      .load_stb  (load_stb),
      .load_val  (load_val),
      .period    (period),
      .ctrl      (ctrl),
      .timeout   (timeout)
   );

   itmr_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_stb (start_stb),
      .stop_stb  (stop_stb),
      .load_stb  (load_stb),
      .load_val  (load_val),
      .period    (period),
      .cont      (ctrl.cont),
      .count     (count),
      .running   (running),
      .expire    (expire)
   );

   assign irq = ctrl.irq_en && timeout;

   AST_IRQ_NEEDS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> timeout); // R11
endmodule

// File: tb/itmr_top_tb.sv
module itmr_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int unsigned n_chk = 0;
   int unsigned n_err = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   itmr_top u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // {period, idle clocks after start, expected count} in continuous mode
   localparam logic [95:0] VEC [0:6] = '{
      {32'd100,      32'd0,   32'd100},
      {32'd100,      32'd10,  32'd90},
      {32'd100,      32'd100, 32'd0},
      {32'd100,      32'd101, 32'd100},
      {32'd5,        32'd13,  32'd4},
      {32'h0001_0002,32'd4,   32'h0000_FFFE},
      {32'd0,        32'd3,   32'd0}
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // Called in the low clock phase; the write occupies the next rising edge
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic idle(input int unsigned n);
      for (int unsigned i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic snap(output logic [31:0] v);
      logic [31:0] lo, hi;
      wr(3'd4, 32'hA5A5_5A5A);
      rd(3'd4, lo);
      rd(3'd5, hi);
      v = {hi[15:0], lo[15:0]};
   endtask

   task automatic set_period(input logic [31:0] p);
      wr(3'd2, {16'h0, p[15:0]});
      wr(3'd3, {16'h0, p[31:16]});
   endtask

   initial begin
      logic [31:0] v, s1;
      rst_n = 1'b0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(3'd0, v); check("R1 status", v, 32'h0);
      rd(3'd1, v); check("R1 control", v, 32'h0);
      rd(3'd2, v); check("R1 period lo", v, 32'h0000_FFFF);
      rd(3'd3, v); check("R1 period hi", v, 32'h0000_FFFF);
      rd(3'd4, v); check("R1 snap lo", v, 32'h0);
      rd(3'd5, v); check("R1 snap hi", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      snap(v); check("R1 count after reset", v, 32'hFFFF_FFFF);

      // R7 R4 table of continuous-mode runs
      for (int i = 0; i < 7; i++) begin
         wr(3'd1, 32'h8);
         set_period(VEC[i][95:64]);
         wr(3'd1, 32'h6);
         idle(VEC[i][63:32]);
         snap(v);
         check("R7 continuous count", v, VEC[i][31:0]);
      end
      wr(3'd1, 32'h8);
      wr(3'd0, 32'h0);

      // R2 half-word storage and read masking
      wr(3'd3, 32'hFFFF_0002);
      wr(3'd2, 32'hDEAD_0007);
      rd(3'd2, v); check("R2 period lo readback", v, 32'h0000_0007);
      rd(3'd3, v); check("R2 period hi readback", v, 32'h0000_0002);
      // R3 period write loads the counter while stopped
      snap(v); check("R3 counter loaded", v, 32'h0002_0007);
      rd(3'd0, v); check("R3 still stopped", v, 32'h0);

      // R10 high snapshot write ignored while count moves
      wr(3'd1, 32'h6);
      idle(4);
      wr(3'd5, 32'h1234_5678);
      rd(3'd4, v); check("R10 snap lo unchanged", v, 32'h0000_0007);
      rd(3'd5, v); check("R10 snap hi unchanged", v, 32'h0000_0002);
      rd(3'd0, v); check("R4 running flag", v & 32'h2, 32'h2);

      // R5 stop halts and holds the count
      wr(3'd1, 32'h8);
      set_period(32'd1000);
      wr(3'd1, 32'h6);
      idle(5);
      wr(3'd1, 32'hA);
      snap(s1); check("R5 count at stop", s1, 32'd994);
      idle(7);
      snap(v); check("R5 count held", v, 32'd994);
      rd(3'd0, v); check("R5 not running", v, 32'h0);

      // R5 R12 start and stop together; control readback
      wr(3'd1, 32'hF);
      rd(3'd0, v); check("R5 stop wins over start", v & 32'h2, 32'h0);
      rd(3'd1, v); check("R12 control readback", v, 32'h3);

      // R9 expiry on the same edge as a status write keeps the flag
      wr(3'd1, 32'h8);
      set_period(32'd0);
      wr(3'd1, 32'h6);
      idle(2);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); check("R9 set wins over clear", v, 32'h3);
      wr(3'd1, 32'h8);
      wr(3'd0, 32'h0);
      rd(3'd0, v); check("R9 clear", v, 32'h0);

      // R8 R6 one-shot expiry
      set_period(32'd3);
      wr(3'd1, 32'h4);
      idle(3);
      rd(3'd0, v); check("R6 no timeout before P+1", v, 32'h2);
      idle(1);
      rd(3'd0, v); check("R6 R8 timeout and halted", v, 32'h1);
      snap(v); check("R8 reloaded period", v, 32'd3);
      idle(5);
      snap(v); check("R8 waits for start", v, 32'd3);
      check("R11 irq disabled", {31'b0, irq}, 32'h0);
      wr(3'd1, 32'h1);
      #1;
      check("R11 irq enabled", {31'b0, irq}, 32'h1);
      wr(3'd0, 32'h0);
      #1;
      check("R11 irq drops on clear", {31'b0, irq}, 32'h0);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog got=hung exp=done");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end
endmodule